// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This unit executes the second opcode byte of an 8-bit processor's bit-manipulation prefix group. The byte is split into a two-bit group field, a three-bit selector and a three-bit operand field. Each operation takes the operand byte and the current flag byte. It returns the new operand value, a write-back enable, the updated flags and the decoded operand register index.

The operations are:
- eight rotate and shift variants,
- a bit test,
- a bit clear,
- a bit set.

The surrounding core supplies the operand. For the memory form, the core fetches the operand itself. The core then commits the result when the write-back enable is high. Memory sequencing, the double-prefix indexed forms and cycle timing belong to the core, not to this unit.

The unit has one register stage. An operation presented with `valid_i` appears on the outputs on the next rising clock edge, together with `valid_o`.

Top module: `rsb_unit`

## Requirements
- R1: An operation accepted with `valid_i` high at a rising edge produces `valid_o` high with its results after that same edge. `valid_o` and `wr_en_o` are low while `rst_ni` is low and in any cycle that follows an edge where `valid_i` was low.
- R2: `reg_idx_o` equals opcode bits 2:0. The encoding is B=0, C=1, D=2, E=3, H=4, L=5, memory=6 and A=7. `mem_op_o` is high exactly when the index is 6.
- R3: Group 0 (opcode bits 7:6 = 00), selector 0 (0x00) rotates left circularly, copying bit 7 into bit 0 and into C. Selector 1 (0x08) rotates right circularly, copying bit 0 into bit 7 and into C.
- R4: Selector 2 (0x10) rotates left through carry: the old C enters bit 0 and bit 7 goes to C. Selector 3 (0x18) rotates right through carry: the old C enters bit 7 and bit 0 goes to C.
- R5: Selector 4 (0x20) shifts left with 0 into bit 0 and bit 7 into C. Selector 5 (0x28) shifts right keeping bit 7 unchanged, with bit 0 into C.
- R6: Selector 6 (0x30) shifts left with 1 into bit 0 and bit 7 into C. Selector 7 (0x38) shifts right with 0 into bit 7 and bit 0 into C.
- R7: The flag byte layout is C=bit 0, N=bit 1, P/V=bit 2, H=bit 4, Z=bit 6 and S=bit 7. For every rotate and shift:
  - S is result bit 7;
  - Z is 1 when the result is zero;
  - P/V is 1 when the result has an even number of ones;
  - H and N are 0;
  - flag bits 3 and 5 keep their input values.
- R8: Group 1 (0x40 + 8*b, with b in opcode bits 5:3) tests bit b. It behaves as follows:
  - Write-back is low and `result_o` equals the operand.
  - Z is the inverse of the tested bit, and P/V equals Z.
  - S is 1 only when b is 7 and the bit is 1.
  - H is 1 and N is 0.
  - C and flag bits 3 and 5 are unchanged.
- R9: Group 2 (0x80 + 8*b) clears bit b of the operand, leaves the other bits as they were and returns the flag byte unchanged.
- R10: Group 3 (0xC0 + 8*b) sets bit b of the operand, leaves the other bits as they were and returns the flag byte unchanged.
- R11: `wr_en_o` is high with `valid_o` for every rotate, shift, clear and set, and low for every bit test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 8 | Second opcode byte |
| data_i | input | DW | Operand value |
| flags_i | input | 8 | Current flag byte |
| valid_o | output | 1 | Results valid |
| result_o | output | DW | New operand value |
| wr_en_o | output | 1 | Write the result back to the operand |
| flags_o | output | 8 | Updated flag byte |
| reg_idx_o | output | 3 | Decoded operand register index |
| mem_op_o | output | 1 | Operand is the memory location |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle valid latency;
- that the operand index and the memory indication follow the opcode;
- that a bit test never writes;
- the fixed H, N and C behaviour of the bit test;
- that clear and set leave the flags untouched and really clear or set the selected bit;
- that every rotate and shift reports even parity of its own result with H and N clear.

The following depend on operand and carry values, so only the bench's scenarios can show them:
- the data movement of each of the eight rotate and shift variants, including carry entry and the fill bit;
- the zero and sign flags;
- the rule that sign is set only for bit 7 in a bit test.

The bench runs all 256 opcodes against several operand and flag patterns. It adds directed edge values such as all-zero, all-one and single top or bottom bits.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL_CIRC = 3'd0,
    SH_ROR_CIRC = 3'd1,
    SH_ROL_CY   = 3'd2,
    SH_ROR_CY   = 3'd3,
    SH_SHL_ZERO = 3'd4,
    SH_SHR_SIGN = 3'd5,
    SH_SHL_ONE  = 3'd6,
    SH_SHR_ZERO = 3'd7
  } shift_e;

  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned FLAG_C  = 0;
  localparam int unsigned FLAG_N  = 1;
  localparam int unsigned FLAG_PV = 2;
  localparam int unsigned FLAG_H  = 4;
  localparam int unsigned FLAG_Z  = 6;
  localparam int unsigned FLAG_S  = 7;
  localparam int unsigned SEL_W   = 3;
  localparam logic [SEL_W-1:0] MEM_IDX = 3'd6;
endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
  import rsb_pkg::*;
(
  input  logic [7:0]       op_i,
  output grp_e             grp_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [SEL_W-1:0] reg_idx_o,
  output logic             mem_op_o
);
  assign grp_o     = grp_e'(op_i[7:6]);
  assign sel_o     = op_i[5:3];
  assign reg_idx_o = op_i[2:0];
  assign mem_op_o  = (op_i[2:0] == MEM_IDX);
endmodule

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]    data_i,
  input  logic             cy_i,
  input  logic [SEL_W-1:0] kind_i,
  output logic [DW-1:0]    res_o,
  output logic             cy_o
);
  logic msb, lsb;
  assign msb = data_i[DW-1];
  assign lsb = data_i[0];

  always_comb begin
    res_o = data_i;
    cy_o  = cy_i;
    unique case (shift_e'(kind_i))
      SH_ROL_CIRC: begin res_o = {data_i[DW-2:0], msb};  cy_o = msb; end
      SH_ROR_CIRC: begin res_o = {lsb, data_i[DW-1:1]};  cy_o = lsb; end
      SH_ROL_CY:   begin res_o = {data_i[DW-2:0], cy_i}; cy_o = msb; end
      SH_ROR_CY:   begin res_o = {cy_i, data_i[DW-1:1]}; cy_o = lsb; end
      SH_SHL_ZERO: begin res_o = {data_i[DW-2:0], 1'b0}; cy_o = msb; end
      SH_SHR_SIGN: begin res_o = {msb, data_i[DW-1:1]};  cy_o = lsb; end
      SH_SHL_ONE:  begin res_o = {data_i[DW-2:0], 1'b1}; cy_o = msb; end
      SH_SHR_ZERO: begin res_o = {1'b0, data_i[DW-1:1]}; cy_o = lsb; end
      default:     begin res_o = data_i;                 cy_o = cy_i; end
    endcase
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]    data_i,
  input  grp_e             grp_i,
  input  logic [SEL_W-1:0] bitn_i,
  output logic [DW-1:0]    res_o,
  output logic             tested_o
);
  logic [DW-1:0] mask;

  // one-hot mask, one slice per bit position
  for (genvar g = 0; g < DW; g++) begin : g_mask
    assign mask[g] = (bitn_i == SEL_W'(g));
  end

  assign tested_o = |(data_i & mask);

  always_comb begin
    unique case (grp_i)
      GRP_CLR: res_o = data_i & ~mask;
      GRP_SET: res_o = data_i | mask;
      default: res_o = data_i;
    endcase
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        op_i,
  input  logic [DW-1:0]     data_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [DW-1:0]     result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [SEL_W-1:0]  reg_idx_o,
  output logic              mem_op_o
);
  localparam logic [SEL_W-1:0] TOP_BIT = SEL_W'(DW - 1);

  grp_e             grp;
  logic [SEL_W-1:0] sel, idx;
  logic             mem;
  logic [DW-1:0]    sh_res, bo_res, nxt_res;
  logic             sh_cy, tested, nxt_wr;
  logic [FLAG_W-1:0] nxt_flags;

  rsb_decode u_dec (
    .op_i      (op_i),
    .grp_o     (grp),
    .sel_o     (sel),
    .reg_idx_o (idx),
    .mem_op_o  (mem)
  );

  rsb_shift #(.DW(DW)) u_shift (
    .data_i (data_i),
    .cy_i   (flags_i[FLAG_C]),
    .kind_i (sel),
    .res_o  (sh_res),
    .cy_o   (sh_cy)
  );

  rsb_bitop #(.DW(DW)) u_bitop (
    .data_i   (data_i),
    .grp_i    (grp),
    .bitn_i   (sel),
    .res_o    (bo_res),
    .tested_o (tested)
  );

  always_comb begin
    nxt_res   = bo_res;
    nxt_flags = flags_i;
    nxt_wr    = 1'b1;
    unique case (grp)
      GRP_SHIFT: begin
        nxt_res            = sh_res;
        nxt_flags[FLAG_S]  = sh_res[DW-1];
        nxt_flags[FLAG_Z]  = ~|sh_res;
        nxt_flags[FLAG_H]  = 1'b0;
        nxt_flags[FLAG_PV] = ~^sh_res;
        nxt_flags[FLAG_N]  = 1'b0;
        nxt_flags[FLAG_C]  = sh_cy;
      end
      GRP_TEST: begin
        nxt_wr             = 1'b0;
        nxt_res            = data_i;
        nxt_flags[FLAG_S]  = tested & (sel == TOP_BIT);
        nxt_flags[FLAG_Z]  = ~tested;
        nxt_flags[FLAG_H]  = 1'b1;
        nxt_flags[FLAG_PV] = ~tested;
        nxt_flags[FLAG_N]  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
      reg_idx_o <= '0;
      mem_op_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i & nxt_wr;
      if (valid_i) begin
        result_o  <= nxt_res;
        flags_o   <= nxt_flags;
        reg_idx_o <= idx;
        mem_op_o  <= mem;
      end
    end
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk
  import rsb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        op_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              valid_o,
  input logic [DW-1:0]     result_o,
  input logic              wr_en_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic [SEL_W-1:0]  reg_idx_o,
  input logic              mem_op_o
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wr_en_o); // R1
  AST_INDEX_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> reg_idx_o == $past(op_i[2:0]) && mem_op_o == ($past(op_i[2:0]) == 3'd6)); // R2
  AST_SHIFT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[7:6] == 2'b00 |=>
      flags_o[FLAG_PV] == ~^result_o && !flags_o[FLAG_H] && !flags_o[FLAG_N]); // R7
  AST_TEST_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[7:6] == 2'b01 |=>
      flags_o[FLAG_H] && !flags_o[FLAG_N] && flags_o[FLAG_C] == $past(flags_i[FLAG_C])
      && flags_o[FLAG_PV] == flags_o[FLAG_Z]); // R8
  AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[7:6] == 2'b01 |=> !wr_en_o); // R11
  AST_CLR_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[7:6] == 2'b10 |=>
      !result_o[$past(op_i[5:3])] && flags_o == $past(flags_i) && wr_en_o); // R9
  AST_SET_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[7:6] == 2'b11 |=>
      result_o[$past(op_i[5:3])] && flags_o == $past(flags_i) && wr_en_o); // R10
endmodule

bind rsb_unit rsb_unit_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .flags_i   (flags_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .flags_o   (flags_o),
  .reg_idx_o (reg_idx_o),
  .mem_op_o  (mem_op_o)
);

// File: tb/rsb_unit_test.sv
`timescale 1ns/1ps
module rsb_unit_test;
  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    logic       wr;
    logic [2:0] idx;
    logic       mem;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] op_i = '0, data_i = '0, flags_i = '0;
  logic       valid_o, wr_en_o, mem_op_o;
  logic [7:0] result_o, flags_o;
  logic [2:0] reg_idx_o;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  rsb_unit #(.DW(8)) uut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_i), .op_i (op_i),
    .data_i (data_i), .flags_i (flags_i), .valid_o (valid_o),
    .result_o (result_o), .wr_en_o (wr_en_o), .flags_o (flags_o),
    .reg_idx_o (reg_idx_o), .mem_op_o (mem_op_o)
  );

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] d, input logic [7:0] f);
    exp_t e;
    logic c, t;
    logic [2:0] b;
    b = op[5:3];
    e.idx = op[2:0];
    e.mem = (op[2:0] == 3'd6);
    e.flg = f;
    e.wr  = 1'b1;
    e.res = d;
    case (op[7:6])
      2'b00: begin
        case (b)
          3'd0: begin e.res = {d[6:0], d[7]}; c = d[7]; e.tag = "R3"; end
          3'd1: begin e.res = {d[0], d[7:1]}; c = d[0]; e.tag = "R3"; end
          3'd2: begin e.res = {d[6:0], f[0]}; c = d[7]; e.tag = "R4"; end
          3'd3: begin e.res = {f[0], d[7:1]}; c = d[0]; e.tag = "R4"; end
          3'd4: begin e.res = {d[6:0], 1'b0}; c = d[7]; e.tag = "R5"; end
          3'd5: begin e.res = {d[7], d[7:1]}; c = d[0]; e.tag = "R5"; end
          3'd6: begin e.res = {d[6:0], 1'b1}; c = d[7]; e.tag = "R6"; end
          default: begin e.res = {1'b0, d[7:1]}; c = d[0]; e.tag = "R6"; end
        endcase
        e.flg[7] = e.res[7];
        e.flg[6] = (e.res == 8'h00);
        e.flg[4] = 1'b0;
        e.flg[2] = ($countones(e.res) % 2 == 0);
        e.flg[1] = 1'b0;
        e.flg[0] = c;
      end
      2'b01: begin
        t = d[b];
        e.wr = 1'b0;
        e.flg[7] = t && (b == 3'd7);
        e.flg[6] = !t;
        e.flg[4] = 1'b1;
        e.flg[2] = !t;
        e.flg[1] = 1'b0;
        e.tag = "R8";
      end
      2'b10: begin e.res[b] = 1'b0; e.tag = "R9"; end
      default: begin e.res[b] = 1'b1; e.tag = "R10"; end
    endcase
    return e;
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] d, input logic [7:0] f);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; data_i = d; flags_i = f;
    sb.push_back(model(op, d, f));
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        check("R1", "unexpected valid_o", 8'd1, 8'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "result", result_o, e.res);
        check((e.tag == "R8" || e.tag == "R9" || e.tag == "R10") ? e.tag : "R7", "flags", flags_o, e.flg);
        check("R11", "wr_en", {7'd0, wr_en_o}, {7'd0, e.wr});
        check("R2", "reg_idx", {5'd0, reg_idx_o}, {5'd0, e.idx});
        check("R2", "mem_op", {7'd0, mem_op_o}, {7'd0, e.mem});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h81; pats[3] = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1", "reset valid_o", {7'd0, valid_o}, 8'd0);
    check("R1", "reset wr_en_o", {7'd0, wr_en_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle valid_o", {7'd0, valid_o}, 8'd0);

    // directed corners
    drive(8'h00, 8'h81, 8'h00); // R3: 0x03, C=1
    drive(8'h19, 8'h01, 8'h01); // R4: carry in to bit 7 -> 0x80
    drive(8'h12, 8'h80, 8'h00); // R4: result zero, C=1
    drive(8'h2F, 8'h80, 8'h00); // R5: sign kept -> 0xC0
    drive(8'h36, 8'h00, 8'h00); // R6: one fill -> 0x01
    drive(8'h3F, 8'h01, 8'hFF); // R6: zero result, bits 3/5 kept
    drive(8'h7F, 8'h80, 8'h00); // R8: bit 7 set -> S=1
    drive(8'h47, 8'hFE, 8'h29); // R8: bit 0 clear -> Z=1
    drive(8'hBE, 8'hFF, 8'hD7); // R9
    drive(8'hC6, 8'h00, 8'h28); // R10
    idle();
    @(negedge clk);
    check("R1", "valid_o after idle", {7'd0, valid_o}, 8'd0);
    check("R1", "wr_en_o after idle", {7'd0, wr_en_o}, 8'd0);

    // sweep every opcode
    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 256; o++) begin
        drive(8'(o), pats[p] ^ 8'(o), (p[0]) ? 8'hFF : 8'h00);
      end
    end
    idle();
    repeat (2) @(negedge clk);
    check("R1", "scoreboard drained", 8'(sb.size()), 8'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule